// File: doc/BRIEF.md
# Error-Correcting Word Guard with Byte-Merge Writes

This block sits between a requester and a synchronous word store. Each stored word is 32 data bits plus 7 check bits. On every store the block generates the check bits. On every fetch it regenerates them, compares them with the stored copy, corrects any single flipped bit and reports any two flipped bits as uncorrectable. The check code is an extended Hamming code: six position-parity bits plus one overall parity bit.

A store that enables all byte lanes goes straight to memory. A store with any lane disabled becomes a four-phase sequence: fetch the whole word, correct it, splice the enabled bytes into it, and store it back with fresh check bits. If the fetch finds an uncorrectable word, the store is dropped and the response carries the uncorrectable flag.

The requester sees a ready/valid request port and a one-cycle response pulse for every request. The memory side is a plain enable/write-enable port whose fetched data appears one cycle after the enable.

Top module: `ecc_word_guard`

## Requirements
- R1: Every memory write carries check bits c[6:0] defined as follows. Data bit k sits at the k-th codeword position, counting upward from 3 and skipping powers of two. For i in 0..5, c[i] is the XOR of the data bits whose position has bit i set. c[6] is the XOR of all 32 data bits and c[5:0].
- R2: A write request with all four byte enables set issues exactly one memory write of the request data, with no memory read. Its response arrives in the second cycle after acceptance, with rsp_rdata zero and both flags low.
- R3: A read of a clean word issues one memory read and returns the stored data in the third cycle after acceptance, with both flags low.
- R4: A read of a word with one flipped data bit returns the original data with rsp_sec high and rsp_ded low.
- R5: A read of a word with one flipped check bit (c[0]..c[6], including the overall bit) returns the stored data unchanged with rsp_sec high and rsp_ded low.
- R6: A read of a word with two flipped bits (data or check) returns the stored data bits uncorrected with rsp_ded high and rsp_sec low.
- R7: A write with some byte enables clear first reads the word, then writes back the corrected old word in which byte b (bits 8b+7..8b) is replaced by the request byte when req_be[b] is set, with R1 check bits. Its response arrives in the fourth cycle after acceptance, with rsp_sec set if the read phase corrected a bit.
- R8: If the read phase of a partial write finds an uncorrectable word, no memory write occurs, and the response arrives in the third cycle after acceptance with rsp_ded high.
- R9: req_ready is low from the accepting edge until the response cycle. It is high again in the response cycle, and rsp_valid is a single-cycle pulse.
- R10: While reset is asserted, req_ready, rsp_valid and mem_en are low. req_ready is high within three cycles after reset is released.
- R11: rsp_sec and rsp_ded are never both high, and both are low whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle; request accepted when both are high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 4 | Byte lane enables for writes |
| req_addr_i | input | 8 | Word address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_rdata_o | output | 32 | Read data (zero for writes) |
| rsp_sec_o | output | 1 | Single error corrected |
| rsp_ded_o | output | 1 | Uncorrectable double error detected |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 8 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_wchk_o | output | 7 | Memory write check bits |
| mem_rdata_i | input | 32 | Fetched data, valid one cycle after a read enable |
| mem_rchk_i | input | 7 | Fetched check bits |

## Verification
A wrong sequencer state shows up on the memory port within one cycle. It appears as a write where a fetch belongs, a missing write-back, or a response pulse that comes early or late, and a wrong state also keeps req_ready out of step. A wrong syndrome mapping does not show on the memory port. It appears only at the next fetch of a damaged word, as a flipped data bit in the returned data or a wrong flag. A wrong splice or a wrong check-bit generator appears in the stored word at the write-back edge, so the bench compares the store contents against its own encoding right after each write.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD_ISSUE,
    ST_RD_DEC,
    ST_MW_ISSUE,
    ST_MW_DEC,
    ST_MW_WB
  } guard_st_e;

  // Number of position-parity bits needed to cover dw data bits.
  function automatic int hamming_bits(int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Codeword position of data bit k: positions from 3 upward, powers of two skipped.
  function automatic int data_pos(int k);
    int cnt;
    cnt = 0;
    for (int p = 3; p < 4096; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == k) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/ecc_chk_gen.sv
module ecc_chk_gen
  import ecc_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HAM_W = hamming_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  logic [HAM_W-1:0] ham;

  for (genvar gi = 0; gi < HAM_W; gi++) begin : g_ham
    logic [DATA_W-1:0] sel;
    for (genvar gk = 0; gk < DATA_W; gk++) begin : g_bit
      localparam int POS = data_pos(gk);
      if (((POS >> gi) & 1) == 1) begin : g_on
        assign sel[gk] = data_i[gk];
      end else begin : g_off
        assign sel[gk] = 1'b0;
      end
    end
    assign ham[gi] = ^sel;
  end

  assign chk_o = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/ecc_chk_fix.sv
module ecc_chk_fix
  import ecc_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HAM_W = hamming_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic [DATA_W-1:0] raw_data_i,
  input  logic [CHK_W-1:0]  raw_chk_i,
  output logic [DATA_W-1:0] fix_data_o,
  output logic              sec_o,
  output logic              ded_o
);

  logic [CHK_W-1:0]  recalc;
  logic [HAM_W-1:0]  syn;
  logic              par_odd;
  logic [DATA_W-1:0] flip;
  logic              data_hit;
  logic              chk_hit;

  ecc_chk_gen #(.DATA_W(DATA_W)) u_regen (
    .data_i (raw_data_i),
    .chk_o  (recalc)
  );

  assign syn     = recalc[HAM_W-1:0] ^ raw_chk_i[HAM_W-1:0];
  assign par_odd = ^{raw_data_i, raw_chk_i};

  for (genvar gk = 0; gk < DATA_W; gk++) begin : g_flip
    localparam int POS = data_pos(gk);
    assign flip[gk] = par_odd & (syn == HAM_W'(POS));
  end

  assign data_hit   = |flip;
  // zero or a single set bit: the error sits in a check bit
  assign chk_hit    = (syn & (syn - 1'b1)) == '0;
  assign sec_o      = par_odd & (data_hit | chk_hit);
  assign ded_o      = (~par_odd & (syn != '0)) | (par_odd & ~data_hit & ~chk_hit);
  assign fix_data_o = raw_data_i ^ flip;

endmodule

// File: rtl/ecc_byte_merge.sv
module ecc_byte_merge #(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [NB-1:0]     be_i,
  output logic [DATA_W-1:0] out_o
);

  for (genvar gb = 0; gb < NB; gb++) begin : g_lane
    assign out_o[8*gb +: 8] = be_i[gb] ? new_i[8*gb +: 8] : old_i[8*gb +: 8];
  end

endmodule

// File: rtl/ecc_word_guard.sv
module ecc_word_guard
  import ecc_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int NB    = DATA_W / 8,
  localparam int CHK_W = hamming_bits(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [NB-1:0]     req_be_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_sec_o,
  output logic              rsp_ded_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [CHK_W-1:0]  mem_wchk_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [CHK_W-1:0]  mem_rchk_i
);

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  guard_st_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wbuf_q, wbuf_d;
  logic [NB-1:0]     be_q;
  logic              keep_sec_q, keep_sec_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;
  logic              rsp_sec_q, rsp_sec_d;
  logic              rsp_ded_q, rsp_ded_d;

  logic              cap_en;
  logic              wbuf_en;
  logic              keep_en;
  logic [DATA_W-1:0] fix_data;
  logic              dec_sec;
  logic              dec_ded;
  logic [DATA_W-1:0] merged;

  ecc_chk_gen #(.DATA_W(DATA_W)) u_gen (
    .data_i (wbuf_q),
    .chk_o  (mem_wchk_o)
  );

  ecc_chk_fix #(.DATA_W(DATA_W)) u_fix (
    .raw_data_i (mem_rdata_i),
    .raw_chk_i  (mem_rchk_i),
    .fix_data_o (fix_data),
    .sec_o      (dec_sec),
    .ded_o      (dec_ded)
  );

  ecc_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .old_i (fix_data),
    .new_i (wbuf_q),
    .be_i  (be_q),
    .out_o (merged)
  );

  assign req_ready_o = (st_q == ST_IDLE) & rst_n_int;
  assign cap_en      = req_valid_i & req_ready_o;
  assign wbuf_en     = cap_en | ((st_q == ST_MW_DEC) & ~dec_ded);
  assign keep_en     = (st_q == ST_MW_DEC);

  // next-state process
  always_comb begin
    st_d        = st_q;
    wbuf_d      = wbuf_q;
    keep_sec_d  = keep_sec_q;
    rsp_valid_d = 1'b0;
    rsp_rdata_d = '0;
    rsp_sec_d   = 1'b0;
    rsp_ded_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cap_en) begin
          wbuf_d = req_wdata_i;
          if (!req_we_i)      st_d = ST_RD_ISSUE;
          else if (&req_be_i) st_d = ST_WR;
          else                st_d = ST_MW_ISSUE;
        end
      end
      ST_WR: begin
        st_d        = ST_IDLE;
        rsp_valid_d = 1'b1;
      end
      ST_RD_ISSUE: st_d = ST_RD_DEC;
      ST_RD_DEC: begin
        st_d        = ST_IDLE;
        rsp_valid_d = 1'b1;
        rsp_rdata_d = fix_data;
        rsp_sec_d   = dec_sec;
        rsp_ded_d   = dec_ded;
      end
      ST_MW_ISSUE: st_d = ST_MW_DEC;
      ST_MW_DEC: begin
        keep_sec_d = dec_sec;
        if (dec_ded) begin
          st_d        = ST_IDLE;
          rsp_valid_d = 1'b1;
          rsp_ded_d   = 1'b1;
        end else begin
          wbuf_d = merged;
          st_d   = ST_MW_WB;
        end
      end
      ST_MW_WB: begin
        st_d        = ST_IDLE;
        rsp_valid_d = 1'b1;
        rsp_sec_d   = keep_sec_q;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      wbuf_q      <= '0;
      be_q        <= '0;
      keep_sec_q  <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_sec_q   <= 1'b0;
      rsp_ded_q   <= 1'b0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_rdata_q <= rsp_rdata_d;
      rsp_sec_q   <= rsp_sec_d;
      rsp_ded_q   <= rsp_ded_d;
      if (cap_en) begin
        addr_q <= req_addr_i;
        be_q   <= req_be_i;
      end
      if (wbuf_en) wbuf_q <= wbuf_d;
      if (keep_en) keep_sec_q <= keep_sec_d;
    end
  end

  assign mem_en_o    = (st_q == ST_WR) | (st_q == ST_RD_ISSUE) |
                       (st_q == ST_MW_ISSUE) | (st_q == ST_MW_WB);
  assign mem_we_o    = (st_q == ST_WR) | (st_q == ST_MW_WB);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wbuf_q;

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_sec_o   = rsp_sec_q;
  assign rsp_ded_o   = rsp_ded_q;

endmodule

// File: rtl/ecc_word_guard_chk.sv
module ecc_word_guard_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NB     = 4,
  parameter int CHK_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_we_i,
  input logic [NB-1:0]     req_be_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic              rsp_valid_o,
  input logic              rsp_sec_o,
  input logic              rsp_ded_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [CHK_W-1:0]  mem_wchk_o
);

  a_r1_write_parity_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && mem_we_o) |-> ((^{mem_wdata_o, mem_wchk_o}) == 1'b0));

  a_r2_full_write_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_we_i && (&req_be_i))
    |=> (mem_en_o && mem_we_o && mem_wdata_o == $past(req_wdata_i)));

  a_r3_read_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_we_i)
    |=> (mem_en_o && !mem_we_o && mem_addr_o == $past(req_addr_i)));

  a_r7_partial_reads_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_we_i && !(&req_be_i))
    |=> (mem_en_o && !mem_we_o));

  a_r9_busy_during_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> !req_ready_o);

  a_r9_single_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_sec_o && rsp_ded_o));

  a_r11_flags_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_sec_o && !rsp_ded_o));

endmodule

bind ecc_word_guard ecc_word_guard_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .NB     (NB),
  .CHK_W  (CHK_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_we_i    (req_we_i),
  .req_be_i    (req_be_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_sec_o   (rsp_sec_o),
  .rsp_ded_o   (rsp_ded_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_wchk_o  (mem_wchk_o)
);

// File: tb/ecc_word_guard_tb_top.sv
module ecc_word_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int CW = 7;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_ready, req_we;
  logic [NB-1:0] req_be;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid, rsp_sec, rsp_ded;
  logic [DW-1:0] rsp_rdata;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [CW-1:0] mem_wchk, mem_rchk;

  // store model with error injection port
  logic [DW-1:0] st_d [0:(1<<AW)-1];
  logic [CW-1:0] st_c [0:(1<<AW)-1];
  logic          inj_go;
  logic [AW-1:0] inj_addr;
  logic [DW-1:0] inj_dmask;
  logic [CW-1:0] inj_cmask;
  int            wr_cnt, rd_cnt;

  int  n_chk, n_fail;
  bit  done;

  ecc_word_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_be_i(req_be), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rsp_sec_o(rsp_sec), .rsp_ded_o(rsp_ded),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_wchk_o(mem_wchk),
    .mem_rdata_i(mem_rdata), .mem_rchk_i(mem_rchk)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (inj_go) begin
      st_d[inj_addr] <= st_d[inj_addr] ^ inj_dmask;
      st_c[inj_addr] <= st_c[inj_addr] ^ inj_cmask;
    end else if (mem_en && mem_we) begin
      st_d[mem_addr] <= mem_wdata;
      st_c[mem_addr] <= mem_wchk;
      wr_cnt <= wr_cnt + 1;
    end else if (mem_en) begin
      mem_rdata <= st_d[mem_addr];
      mem_rchk  <= st_c[mem_addr];
      rd_cnt <= rd_cnt + 1;
    end
  end

  // behavioural reference encoding: build the codeword by positions
  function automatic logic [CW-1:0] ref_enc(logic [DW-1:0] d);
    logic [63:0] cw;
    logic [CW-1:0] c;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p <= DW + CW - 1; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    c = '0;
    for (int i = 0; i < CW - 1; i++) begin
      for (int p = 1; p <= DW + CW - 1; p++)
        if (((p >> i) & 1) == 1) c[i] = c[i] ^ cw[p];
    end
    c[CW-1] = (^d) ^ (^c[CW-2:0]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [DW-1:0] dm,
                        input logic [CW-1:0] cm);
    @(negedge clk);
    inj_go = 1'b1; inj_addr = a; inj_dmask = dm; inj_cmask = cm;
    @(negedge clk);
    inj_go = 1'b0;
  endtask

  // issue one request; returns the response and the cycle it arrived in
  task automatic do_req(input logic we, input logic [NB-1:0] be,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output logic sec, output logic ded,
                        output int lat, output int nwr, output int nrd,
                        output bit busy_ok);
    int w0, r0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_be = be; req_addr = a; req_wdata = wd;
    w0 = wr_cnt; r0 = rd_cnt;
    busy_ok = req_ready;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    for (int n = 1; n <= 12; n++) begin
      if (rsp_valid) begin
        lat = n;
        break;
      end
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    if (!req_ready) busy_ok = 1'b0;
    rd = rsp_rdata; sec = rsp_sec; ded = rsp_ded;
    nwr = wr_cnt - w0; nrd = rd_cnt - r0;
    @(negedge clk);
    if (rsp_valid || rsp_sec || rsp_ded) busy_ok = 1'b0;
  endtask

  logic [DW-1:0] gold [0:15];

  task automatic full_write(input int a, input logic [DW-1:0] d);
    logic [DW-1:0] rd; logic sec, ded; int lat, nw, nr; bit bz;
    do_req(1'b1, 4'hF, AW'(a), d, rd, sec, ded, lat, nw, nr, bz);
    gold[a] = d;
    check(lat == 2 && nw == 1 && nr == 0, "R2 direct write timing", 64'(lat), 64'd2);
    check(rd == '0 && !sec && !ded, "R2 write response", {rd, 30'd0, sec, ded}, 64'd0);
    check(st_d[a] == d && st_c[a] == ref_enc(d), "R1 stored code",
          {st_d[a], 25'd0, st_c[a]}, {d, 25'd0, ref_enc(d)});
    check(bz, "R9 busy/ready handshake", 64'(bz), 64'd1);
  endtask

  task automatic read_chk(input int a, input logic [DW-1:0] exp_d, input logic exp_s,
                          input logic exp_e, input string req);
    logic [DW-1:0] rd; logic sec, ded; int lat, nw, nr; bit bz;
    do_req(1'b0, 4'h0, AW'(a), '0, rd, sec, ded, lat, nw, nr, bz);
    check(rd == exp_d && sec == exp_s && ded == exp_e, req,
          {rd, 30'd0, sec, ded}, {exp_d, 30'd0, exp_s, exp_e});
    check(lat == 3 && nr == 1 && nw == 0, "R3 read timing", 64'(lat), 64'd3);
    check(!(sec && ded) && bz, "R11/R9 flags and handshake", {62'd0, sec, ded}, 64'd0);
  endtask

  task automatic partial(input int a, input logic [NB-1:0] be, input logic [DW-1:0] wd,
                         input logic exp_s);
    logic [DW-1:0] rd, m; logic sec, ded; int lat, nw, nr; bit bz;
    m = gold[a];
    for (int b = 0; b < NB; b++) if (be[b]) m[8*b +: 8] = wd[8*b +: 8];
    do_req(1'b1, be, AW'(a), wd, rd, sec, ded, lat, nw, nr, bz);
    gold[a] = m;
    check(lat == 4 && nr == 1 && nw == 1, "R7 partial write sequence", 64'(lat), 64'd4);
    check(sec == exp_s && !ded, "R7 partial write flags", {62'd0, sec, ded},
          {62'd0, exp_s, 1'b0});
    check(st_d[a] == m && st_c[a] == ref_enc(m), "R7 merged word stored",
          {st_d[a], 25'd0, st_c[a]}, {m, 25'd0, ref_enc(m)});
    check(bz, "R9 busy held through write-back", 64'(bz), 64'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] rd; logic sec, ded; int lat, nw, nr; bit bz;
    n_chk = 0; n_fail = 0; done = 1'b0;
    wr_cnt = 0; rd_cnt = 0;
    inj_go = 1'b0; inj_addr = '0; inj_dmask = '0; inj_cmask = '0;
    mem_rdata = '0; mem_rchk = '0;
    req_valid = 1'b0; req_we = 1'b0; req_be = '0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!req_ready && !rsp_valid && !mem_en, "R10 reset state",
          {61'd0, req_ready, rsp_valid, mem_en}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_en, "R10 ready after release",
          {61'd0, req_ready, rsp_valid, mem_en}, 64'd4);

    // clean words
    full_write(0, 32'h0000_0000);
    full_write(1, 32'hFFFF_FFFF);
    full_write(2, 32'hA5A5_5A5A);
    full_write(3, 32'h1234_5678);
    full_write(4, 32'h8000_0001);
    for (int a = 0; a < 5; a++) read_chk(a, gold[a], 1'b0, 1'b0, "R3 clean read");

    // single data-bit errors
    for (int b = 0; b < DW; b += 5) begin
      inject(2, DW'(1) << b, '0);
      read_chk(2, gold[2], 1'b1, 1'b0, "R4 single data error corrected");
      full_write(2, gold[2]);
    end
    inject(3, 32'h8000_0000, '0);
    read_chk(3, gold[3], 1'b1, 1'b0, "R4 top data bit corrected");
    full_write(3, gold[3]);

    // single check-bit errors, including the overall bit
    for (int c = 0; c < CW; c++) begin
      inject(1, '0, CW'(1) << c);
      read_chk(1, gold[1], 1'b1, 1'b0, "R5 check bit error");
      full_write(1, gold[1]);
    end

    // double errors
    inject(4, 32'h0000_0300, '0);
    read_chk(4, gold[4] ^ 32'h0000_0300, 1'b0, 1'b1, "R6 two data bits");
    full_write(4, gold[4]);
    inject(4, 32'h0001_0000, 7'h04);
    read_chk(4, gold[4] ^ 32'h0001_0000, 1'b0, 1'b1, "R6 data plus check bit");
    full_write(4, gold[4]);
    inject(0, '0, 7'h41);
    read_chk(0, gold[0], 1'b0, 1'b1, "R6 two check bits");
    full_write(0, gold[0]);

    // partial writes on clean words
    partial(3, 4'b0001, 32'hDEAD_BEEF, 1'b0);
    partial(3, 4'b0110, 32'hCAFE_F00D, 1'b0);
    partial(2, 4'b1010, 32'h0102_0304, 1'b0);
    partial(1, 4'b1000, 32'h0000_0000, 1'b0);
    read_chk(3, gold[3], 1'b0, 1'b0, "R7 merged word reads back");

    // partial write on a word with a single error: corrected and stored clean
    inject(2, 32'h0000_0010, '0);
    partial(2, 4'b0001, 32'h0000_0077, 1'b1);
    read_chk(2, gold[2], 1'b0, 1'b0, "R7 corrected bytes kept");

    // partial write on an uncorrectable word: dropped
    inject(4, 32'h0000_0005, '0);
    do_req(1'b1, 4'b0010, AW'(4), 32'h0000_AB00, rd, sec, ded, lat, nw, nr, bz);
    check(lat == 3 && nw == 0 && nr == 1, "R8 aborted write timing",
          {32'(lat), 32'(nw)}, {32'd3, 32'd0});
    check(ded && !sec, "R8 abort reports uncorrectable", {62'd0, sec, ded}, 64'd1);
    check(st_d[4] == (gold[4] ^ 32'h0000_0005) && st_c[4] == ref_enc(gold[4]),
          "R8 store untouched", {32'd0, st_d[4]}, {32'd0, gold[4] ^ 32'h0000_0005});
    check(bz, "R9 handshake on abort", 64'(bz), 64'd1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule